// File: doc/BRIEF.md
# Multi-Rectangle Span Clipper

This block trims one horizontal run of pixels against each rectangle of a small set of clip rectangles. A run is described by its leftmost x, its row y, a pixel count and the index of the first source element that feeds it. Rectangles are programmed in screen coordinates through a write port. The block subtracts the drawable's origin to make each one window-relative, and treats the low edges as inclusive and the high edges as exclusive. For every active rectangle the block emits one trimmed run. When the run starts left of the rectangle, the source index advances by the number of pixels cut away, so that the surviving pixels still line up with their source data.

Runs enter on a valid/ready port. A run is taken on a clock edge where `in_valid` and `in_ready` are both high. While the block is producing the outputs for a run, `in_ready` stays low. Outputs leave on a second valid/ready port. An output is held unchanged for as long as `out_ready` is low, and it moves on only on an edge where both `out_valid` and `out_ready` are high. Rectangles are visited from the highest active index down to index 0. The programmed rectangles, the active count and the origin must stay unchanged while a run is being walked.

Two combinational helpers sit beside the walker. The first reports whether one pixel lies inside any active rectangle. The second mirrors a row number against the drawable height.

Top module: `span_clipper`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted run with K active rectangles (K ≥ 1) produces exactly K outputs. `out_rect` takes the values K-1, K-2, ..., 0 in that order, and `out_last` is 1 only on the output for rectangle 0. On the cycle after that output is taken, `out_valid` is 0 and `in_ready` is 1.
- R3: Rectangle i covers window columns from `x1-win_x` up to, but not including, `x2-win_x`, and window rows from `y1-win_y` up to, but not including, `y2-win_y`. A run that lies wholly inside a rectangle comes out unchanged, and `out_y` always equals the run's y.
- R4: If the row is below the rectangle's lowest row, or at or beyond its exclusive top row, the output count is 0, and x and the source index are passed through unchanged.
- R5: If the run starts left of the rectangle's left edge, the source index grows by (left edge − x) modulo 2^16, the count shrinks by the same amount, and x becomes the left edge.
- R6: If the run, after any left trim, reaches the exclusive right edge or beyond it, the count shrinks so that x + count equals the right edge.
- R7: A run lying entirely outside the rectangle in x yields a count of 0, never a negative count.
- R8: With an active count of 0, a run is accepted on the handshake edge and no output is produced.
- R9: While `out_valid` is high, `in_ready` is low. While `out_ready` is low, every output field holds its value.
- R10: `pt_inside` is 1 exactly when (`pt_x`, `pt_y`) satisfies minx ≤ x < maxx and miny ≤ y < maxy for at least one active rectangle, using window-relative edges.
- R11: `fl_out` equals `height − fl_y − 1`, truncated to 16 bits.
- R12: An active count above the number of rectangle slots is treated as the number of slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one rectangle slot |
| cfg_idx | input | 3 | Slot written |
| cfg_x1 | input | 16 | Screen left edge (inclusive), signed |
| cfg_y1 | input | 16 | Screen low row (inclusive), signed |
| cfg_x2 | input | 16 | Screen right edge (exclusive), signed |
| cfg_y2 | input | 16 | Screen top row (exclusive), signed |
| cfg_count | input | 4 | Number of active rectangles |
| win_x | input | 16 | Drawable origin x in screen space, signed |
| win_y | input | 16 | Drawable origin y in screen space, signed |
| height | input | 16 | Drawable height for the row mirror, signed |
| in_valid | input | 1 | Input run valid |
| in_ready | output | 1 | Block can take a run |
| in_x | input | 16 | Run start x, window-relative, signed |
| in_y | input | 16 | Run row, window-relative, signed |
| in_n | input | 16 | Run pixel count, unsigned |
| in_idx | input | 16 | Source index of the first pixel |
| out_valid | output | 1 | Trimmed run valid |
| out_ready | input | 1 | Consumer takes the trimmed run |
| out_x | output | 16 | Trimmed start x |
| out_y | output | 16 | Row of the run |
| out_n | output | 16 | Trimmed count |
| out_idx | output | 16 | Adjusted source index |
| out_rect | output | 3 | Rectangle this output belongs to |
| out_last | output | 1 | Final output of the run |
| pt_x | input | 16 | Pixel test x, signed |
| pt_y | input | 16 | Pixel test y, signed |
| pt_inside | output | 1 | Pixel lies inside an active rectangle |
| fl_y | input | 16 | Row to mirror, signed |
| fl_out | output | 16 | Mirrored row |

## Verification
The hardest situations to reach are the ones where two trims interact. One is a run that starts left of a rectangle and is also cut on the right. Another is a run whose left trim removes every pixel, and a third is a left trim that pushes the source index past its wrap point. These cases only appear for particular combinations of start, length and row. The stimulus therefore sweeps every start column across and past three overlapping rectangles, with lengths from zero to longer than any rectangle, at rows below, inside and above each one. It also adds runs with the source index just below the wrap. The sweep periodically withholds `out_ready`, so that held outputs and the blocked input port are observed in the middle of a walk.

// File: rtl/span_clip_pkg.sv
package span_clip_pkg;
  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_WALK = 1'b1
  } walk_state_e;

  localparam int EXT_BITS = 3;
endpackage

// File: rtl/clip_rect_regs.sv
module clip_rect_regs #(
  parameter int NRECT = 8,
  parameter int CW    = 16,
  localparam int RIW  = $clog2(NRECT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [RIW-1:0]       widx,
  input  logic signed [CW-1:0] wx1,
  input  logic signed [CW-1:0] wy1,
  input  logic signed [CW-1:0] wx2,
  input  logic signed [CW-1:0] wy2,
  output logic signed [CW-1:0] rx1 [NRECT],
  output logic signed [CW-1:0] ry1 [NRECT],
  output logic signed [CW-1:0] rx2 [NRECT],
  output logic signed [CW-1:0] ry2 [NRECT]
);
  for (genvar g = 0; g < NRECT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rx1[g] <= '0;
        ry1[g] <= '0;
        rx2[g] <= '0;
        ry2[g] <= '0;
      end else if (we && widx == RIW'(g)) begin
        rx1[g] <= wx1;
        ry1[g] <= wy1;
        rx2[g] <= wx2;
        ry2[g] <= wy2;
      end
    end
  end
endmodule

// File: rtl/span_clip_core.sv
module span_clip_core #(
  parameter int CW = 16,
  parameter int NW = 16,
  parameter int EW = CW + 3
) (
  input  logic signed [CW-1:0] x,
  input  logic signed [CW-1:0] y,
  input  logic [NW-1:0]        n,
  input  logic [NW-1:0]        idx,
  input  logic signed [EW-1:0] minx,
  input  logic signed [EW-1:0] miny,
  input  logic signed [EW-1:0] maxx,
  input  logic signed [EW-1:0] maxy,
  output logic signed [CW-1:0] ox,
  output logic [NW-1:0]        on,
  output logic [NW-1:0]        oidx
);
  logic signed [EW-1:0] xe, ye, ne;
  logic signed [EW-1:0] xa, na, skip;
  logic [NW-1:0]        ia;

  assign xe = EW'(x);
  assign ye = EW'(y);
  assign ne = $signed({{(EW-NW){1'b0}}, n});

  always_comb begin
    xa   = xe;
    na   = ne;
    ia   = idx;
    skip = '0;
    if (ye < miny || ye >= maxy) begin
      na = '0;
    end else begin
      if (xa < minx) begin
        skip = minx - xa;
        ia   = idx + NW'(skip);
        na   = na - skip;
        xa   = minx;
        if (na < 0) na = '0;
      end
      if (xa + na >= maxx) begin
        na = maxx - xa;
        if (na < 0) na = '0;
      end
    end
  end

  assign ox   = CW'(xa);
  assign on   = NW'(na);
  assign oidx = ia;
endmodule

// File: rtl/pixel_hit.sv
module pixel_hit #(
  parameter int CW = 16,
  parameter int EW = CW + 3
) (
  input  logic                 active,
  input  logic signed [CW-1:0] px,
  input  logic signed [CW-1:0] py,
  input  logic signed [EW-1:0] minx,
  input  logic signed [EW-1:0] miny,
  input  logic signed [EW-1:0] maxx,
  input  logic signed [EW-1:0] maxy,
  output logic                 hit
);
  logic signed [EW-1:0] pxe, pye;
  assign pxe = EW'(px);
  assign pye = EW'(py);
  assign hit = active && (pxe >= minx) && (pxe < maxx) &&
               (pye >= miny) && (pye < maxy);
endmodule

// File: rtl/span_clipper.sv
module span_clipper
  import span_clip_pkg::*;
#(
  parameter int NRECT = 8,
  parameter int CW    = 16,
  parameter int NW    = 16,
  localparam int RIW  = $clog2(NRECT),
  localparam int KW   = $clog2(NRECT + 1),
  localparam int EW   = CW + EXT_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [RIW-1:0]       cfg_idx,
  input  logic signed [CW-1:0] cfg_x1,
  input  logic signed [CW-1:0] cfg_y1,
  input  logic signed [CW-1:0] cfg_x2,
  input  logic signed [CW-1:0] cfg_y2,
  input  logic [KW-1:0]        cfg_count,
  input  logic signed [CW-1:0] win_x,
  input  logic signed [CW-1:0] win_y,
  input  logic signed [CW-1:0] height,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [CW-1:0] in_x,
  input  logic signed [CW-1:0] in_y,
  input  logic [NW-1:0]        in_n,
  input  logic [NW-1:0]        in_idx,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [CW-1:0] out_x,
  output logic signed [CW-1:0] out_y,
  output logic [NW-1:0]        out_n,
  output logic [NW-1:0]        out_idx,
  output logic [RIW-1:0]       out_rect,
  output logic                 out_last,
  input  logic signed [CW-1:0] pt_x,
  input  logic signed [CW-1:0] pt_y,
  output logic                 pt_inside,
  input  logic signed [CW-1:0] fl_y,
  output logic signed [CW-1:0] fl_out
);
  logic signed [CW-1:0] sx1 [NRECT];
  logic signed [CW-1:0] sy1 [NRECT];
  logic signed [CW-1:0] sx2 [NRECT];
  logic signed [CW-1:0] sy2 [NRECT];
  logic signed [EW-1:0] wminx [NRECT];
  logic signed [EW-1:0] wminy [NRECT];
  logic signed [EW-1:0] wmaxx [NRECT];
  logic signed [EW-1:0] wmaxy [NRECT];
  logic [NRECT-1:0]     hits;
  logic [KW-1:0]        eff_count;

  walk_state_e          state;
  logic [RIW-1:0]       cursor;
  logic signed [CW-1:0] h_x, h_y;
  logic [NW-1:0]        h_n, h_idx;

  clip_rect_regs #(.NRECT(NRECT), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(cfg_idx),
    .wx1(cfg_x1), .wy1(cfg_y1), .wx2(cfg_x2), .wy2(cfg_y2),
    .rx1(sx1), .ry1(sy1), .rx2(sx2), .ry2(sy2)
  );

  assign eff_count = (cfg_count > KW'(NRECT)) ? KW'(NRECT) : cfg_count;

  for (genvar g = 0; g < NRECT; g++) begin : g_win
    assign wminx[g] = EW'(sx1[g]) - EW'(win_x);
    assign wminy[g] = EW'(sy1[g]) - EW'(win_y);
    assign wmaxx[g] = EW'(sx2[g]) - EW'(win_x);
    assign wmaxy[g] = EW'(sy2[g]) - EW'(win_y);

    pixel_hit #(.CW(CW), .EW(EW)) u_hit (
      .active(KW'(g) < eff_count),
      .px(pt_x), .py(pt_y),
      .minx(wminx[g]), .miny(wminy[g]), .maxx(wmaxx[g]), .maxy(wmaxy[g]),
      .hit(hits[g])
    );
  end

  assign pt_inside = |hits;
  assign fl_out    = CW'(height - fl_y - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= WS_IDLE;
      cursor <= '0;
      h_x    <= '0;
      h_y    <= '0;
      h_n    <= '0;
      h_idx  <= '0;
    end else if (state == WS_IDLE) begin
      if (in_valid) begin
        h_x   <= in_x;
        h_y   <= in_y;
        h_n   <= in_n;
        h_idx <= in_idx;
        if (eff_count != '0) begin
          state  <= WS_WALK;
          cursor <= RIW'(eff_count - KW'(1));
        end
      end
    end else if (out_ready) begin
      if (cursor == '0) state <= WS_IDLE;
      else              cursor <= cursor - RIW'(1);
    end
  end

  assign in_ready  = (state == WS_IDLE);
  assign out_valid = (state == WS_WALK);
  assign out_last  = out_valid && (cursor == '0);
  assign out_rect  = cursor;
  assign out_y     = h_y;

  span_clip_core #(.CW(CW), .NW(NW), .EW(EW)) u_core (
    .x(h_x), .y(h_y), .n(h_n), .idx(h_idx),
    .minx(wminx[cursor]), .miny(wminy[cursor]),
    .maxx(wmaxx[cursor]), .maxy(wmaxy[cursor]),
    .ox(out_x), .on(out_n), .oidx(out_idx)
  );
endmodule

// File: rtl/span_clipper_checker.sv
module span_clipper_checker #(
  parameter int NRECT = 8,
  parameter int CW    = 16,
  parameter int NW    = 16,
  localparam int RIW  = $clog2(NRECT),
  localparam int KW   = $clog2(NRECT + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [CW-1:0] out_x,
  input logic [NW-1:0]        out_n,
  input logic [NW-1:0]        out_idx,
  input logic [RIW-1:0]       out_rect,
  input logic                 out_last,
  input logic [KW-1:0]        cfg_count
);
  AST_BLOCK_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R9
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_n)
      && $stable(out_idx) && $stable(out_rect)); // R9
  AST_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=>
      out_valid && out_rect == RIW'($past(out_rect) - RIW'(1))); // R2
  AST_LAST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_rect == '0); // R2
  AST_END_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && in_ready); // R2
  AST_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && cfg_count == '0 |=> !out_valid && in_ready); // R8
endmodule

bind span_clipper span_clipper_checker #(.NRECT(NRECT), .CW(CW), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x), .out_n(out_n),
  .out_idx(out_idx), .out_rect(out_rect), .out_last(out_last),
  .cfg_count(cfg_count)
);

// File: tb/span_clipper_test.sv
module span_clipper_test;
  localparam int NRECT = 8;
  localparam int CW = 16;
  localparam int NW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic signed [15:0] cfg_x1 = '0, cfg_y1 = '0, cfg_x2 = '0, cfg_y2 = '0;
  logic [3:0] cfg_count = '0;
  logic signed [15:0] win_x = '0, win_y = '0, height = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_x = '0, in_y = '0;
  logic [15:0] in_n = '0, in_idx = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [15:0] out_x, out_y;
  logic [15:0] out_n, out_idx;
  logic [2:0] out_rect;
  logic out_last;
  logic signed [15:0] pt_x = '0, pt_y = '0;
  logic pt_inside;
  logic signed [15:0] fl_y = '0;
  logic signed [15:0] fl_out;

  int checks = 0;
  int errors = 0;
  int bx1 [NRECT], by1 [NRECT], bx2 [NRECT], by2 [NRECT];
  int ox = 3, oy = 2;
  int nact = 0;
  int span_no = 0;

  always #4 clk = ~clk;

  span_clipper #(.NRECT(NRECT), .CW(CW), .NW(NW)) uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  task automatic wr_rect(input int i, input int a, input int b, input int c, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(i);
    cfg_x1 = 16'(a); cfg_y1 = 16'(b); cfg_x2 = 16'(c); cfg_y2 = 16'(d);
    bx1[i] = a; by1[i] = b; bx2[i] = c; by2[i] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_clip(input int x, input int y, input int n, input int i, input int r,
                             output int ex, output int en, output int ei, output string req);
    int mnx, mny, mxx, mxy;
    mnx = bx1[r] - ox; mny = by1[r] - oy; mxx = bx2[r] - ox; mxy = by2[r] - oy;
    ex = x; en = n; ei = i; req = "R3";
    if (y < mny || y >= mxy) begin
      en = 0; req = "R4";
    end else begin
      if (ex < mnx) begin
        ei = (i + (mnx - ex)) & 16'hFFFF;
        en = en - (mnx - ex);
        ex = mnx; req = "R5";
        if (en < 0) begin en = 0; req = "R7"; end
      end
      if (ex + en >= mxx) begin
        en = mxx - ex;
        if (req == "R3") req = "R6";
        if (en < 0) begin en = 0; req = "R7"; end
      end
    end
  endtask

  task automatic run_span(input int x, input int y, input int n, input int i, input bit stall);
    int ex, en, ei;
    string req;
    @(negedge clk);
    in_x = 16'(x); in_y = 16'(y); in_n = 16'(n); in_idx = 16'(i); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    for (int k = nact - 1; k >= 0; k--) begin
      @(negedge clk);
      expect_clip(x, y, n, i, k, ex, en, ei, req);
      if (stall) begin
        out_ready = 1'b0;
        @(negedge clk);
        check(out_valid && !in_ready, "R9", "valid held while stalled", out_valid, 1);
      end
      out_ready = 1'b1;
      check(out_valid, "R2", "out_valid", out_valid, 1);
      check(out_rect == 3'(k) && out_last == (k == 0), "R2", "rect order",
            out_rect, k);
      check(out_y == 16'(y), "R3", "out_y", out_y, y);
      check(out_x == 16'(ex), req, "out_x", out_x, ex);
      check(out_n == 16'(en), req, "out_n", out_n, en);
      check(out_idx == 16'(ei), req, "out_idx", out_idx, ei);
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, (nact == 0) ? "R8" : "R2", "idle after walk",
          out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R1", "reset state", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1", "after reset", in_ready, 1);

    win_x = 16'(ox); win_y = 16'(oy);
    wr_rect(0, 12, 8, 22, 14);
    wr_rect(1, 5, 10, 9, 20);
    wr_rect(2, 15, 4, 30, 30);

    nact = 0; cfg_count = 4'd0;
    run_span(5, 7, 4, 1, 1'b0);   // R8

    nact = 3; cfg_count = 4'd3;
    begin
      int ys [6];
      int ns [6];
      ys = '{1, 2, 7, 12, 17, 28};
      ns = '{0, 1, 3, 6, 12, 25};
      for (int yi = 0; yi < 6; yi++)
        for (int ni = 0; ni < 6; ni++)
          for (int x = -3; x <= 30; x++) begin
            span_no++;
            run_span(x, ys[yi], ns[ni], 100 + x, (span_no % 7) == 0);
          end
    end
    run_span(-4, 7, 20, 65530, 1'b1);   // R5 index wrap
    run_span(0, 7, 40000, 65535, 1'b0); // R6 long run

    for (int py = -1; py <= 30; py++)
      for (int px = -2; px <= 30; px++) begin
        bit e;
        @(negedge clk);
        pt_x = 16'(px); pt_y = 16'(py);
        #1;
        e = 0;
        for (int r = 0; r < nact; r++)
          if (px >= bx1[r] - ox && px < bx2[r] - ox && py >= by1[r] - oy && py < by2[r] - oy)
            e = 1;
        check(pt_inside == e, "R10", "pixel test", pt_inside, e);
      end

    height = 16'd480;
    begin
      int fy [5];
      fy = '{0, 479, 100, -1, 240};
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        fl_y = 16'(fy[k]);
        #1;
        check(fl_out == 16'(480 - fy[k] - 1), "R11", "row mirror", fl_out, 480 - fy[k] - 1);
      end
    end

    for (int r = 3; r < NRECT; r++) wr_rect(r, 4 + r, 3, 14 + 2 * r, 9 + r);
    cfg_count = 4'd15; nact = NRECT;   // R12
    run_span(2, 6, 20, 7, 1'b1);
    run_span(9, 11, 5, 300, 1'b0);

    summary();
  end
endmodule